// File: doc/BRIEF.md
# Debug Command Frame Sequencer

This block sits above a serial bit engine on a single-wire debug link and turns the fields it receives into debug command frames. Each frame opens with an 8-bit command. The sequencer sorts the command into one of five classes: hardware read, hardware write, firmware read, firmware write, or go/trace. It then collects the 16-bit fields that class needs. It holds off the host for a fixed number of bus cycles set by the class, and for the read classes it hands a 16-bit result back to the bit engine for transmission. Each field of a command frame takes 16 target clock cycles per bit on the wire, so 8 × 16 cycles for the command byte. That timing belongs to the bit engine. The sequencer only sees whole fields arrive.

Hardware frames use a simple internal memory port that carries an address, write data and single-cycle read and write strobes. Firmware-class frames raise a one-cycle start pulse that carries the command byte. The read result is taken from a dedicated firmware data input. The bit engine reads `rx_wide` to learn whether the next field is 8 or 16 bits wide. While `busy` is high, the host is in its mandatory delay window.

The controller has five states. IDLE waits for a command. ADDR collects the address. DIN collects host data. WAIT runs the bus-cycle delay. DOUT offers the result to the bit engine. The transitions are as follows:
- accept-command leads from IDLE to ADDR, DIN or WAIT, depending on the class.
- address-done leads from ADDR to DIN on a write, or to WAIT on a read.
- data-done leads from DIN to WAIT.
- delay-done leads from WAIT to DOUT for the read classes, and to IDLE for the others.
- sent leads from DOUT to IDLE when `tx_done` arrives.
- drop leads from any state other than IDLE back to IDLE on `rx_timeout`.

Top module: `dbg_frame_seq`

## Requirements
- R1: After reset, `busy`, `rx_wide`, `tx_req`, `mem_rd`, `mem_wr` and `fw_start` are all low, and the block waits for a command.
- R2: The class is decoded from the command byte as follows. Bit 7 = 1 selects a hardware command, and within it bit 6 = 1 means write and bit 6 = 0 means read. Bit 7 = 0 with bit 6 = 1 is a firmware write. Bits 7:6 = 00 with bit 5 = 1 is a firmware read. Bits 7:5 = 000 is go/trace.
- R3: A hardware read frame runs command, address, then a 150-cycle delay. `mem_rd` pulses for exactly one cycle, the first delay cycle, with `mem_addr` holding the address. The word read is then offered on `tx_data`.
- R4: A hardware write frame runs command, address, data, then a 150-cycle delay. `mem_wr` pulses once, in the first delay cycle, with the received address and data. The block then returns to idle.
- R5: A firmware read frame runs command, then a 48-cycle delay. `fw_start` pulses once with `fw_cmd` equal to the command. After the delay, `tx_data` carries `fw_rdata`.
- R6: A firmware write frame runs command, 16-bit data, then a 36-cycle delay, with one `fw_start` pulse carrying the command.
- R7: A go/trace frame runs command, then a 76-cycle delay, with one `fw_start` pulse and no returned data.
- R8: `busy` is high for exactly the class delay length in cycles. A field that arrives while `busy` is high is ignored: it changes neither the delay length, the memory contents nor the next frame.
- R9: `rx_wide` is high while the block waits for an address or data field, and low while it waits for a command.
- R10: `rx_timeout` drops the frame in any state other than idle, and returns the block to idle on the next cycle. When a field and a timeout arrive in the same cycle, the timeout wins and the field is discarded. In idle, a command that arrives together with a timeout is not accepted.
- R11: `tx_req` stays high with stable `tx_data` until `tx_done` or a timeout, and falls on the cycle after `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle pulse: a complete field has arrived from the bit engine |
| rx_data | input | 16 | Received field; the command uses bits 7:0 |
| rx_timeout | input | 1 | Bit engine timeout between host edges |
| rx_wide | output | 1 | Next expected field is 16 bits (low: 8-bit command) |
| busy | output | 1 | Mandatory delay in progress; host fields are ignored |
| tx_req | output | 1 | Result word ready for transmission |
| tx_data | output | 16 | Result word |
| tx_done | input | 1 | Bit engine finished sending the result |
| mem_addr | output | 16 | Memory port address |
| mem_wdata | output | 16 | Memory port write data; also the firmware-write data word |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| fw_start | output | 1 | One-cycle start pulse for a firmware-class command |
| fw_cmd | output | 8 | Command byte of the current frame |
| fw_rdata | input | 16 | Firmware result word, sampled in the second delay cycle |

## Verification
Two functions can fall in the same cycle: the acceptance of a field and the drop on timeout. The bench provokes this by raising `rx_valid` and `rx_timeout` together, both while an address is expected and while a command is expected. It then judges the outcome at the ports. `rx_wide` and `busy` must be low, no read strobe may appear, and a following go/trace frame must run with its full 76-cycle delay. A field injected in the middle of every delay window is judged in the same way, through the delay length and through the memory contents that later reads return.

// File: rtl/dbg_frame_pkg.sv
package dbg_frame_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DIN,
        ST_WAIT,
        ST_DOUT
    } seq_state_t;

    typedef enum logic [2:0] {
        CL_HW_RD,
        CL_HW_WR,
        CL_FW_RD,
        CL_FW_WR,
        CL_GO
    } cmd_class_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_frame_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] cmd,
    output cmd_class_t       cls,
    output logic             need_addr,
    output logic             need_din,
    output logic             gives_data
);
    localparam int HW_BIT = CMD_W - 1;
    localparam int WR_BIT = CMD_W - 2;
    localparam int FR_BIT = CMD_W - 3;

    always_comb begin
        if (cmd[HW_BIT]) begin
            cls = cmd[WR_BIT] ? CL_HW_WR : CL_HW_RD;
        end else if (cmd[WR_BIT]) begin
            cls = CL_FW_WR;
        end else if (cmd[FR_BIT]) begin
            cls = CL_FW_RD;
        end else begin
            cls = CL_GO;
        end
    end

    always_comb begin
        need_addr  = (cls == CL_HW_RD) || (cls == CL_HW_WR);
        need_din   = (cls == CL_HW_WR) || (cls == CL_FW_WR);
        gives_data = (cls == CL_HW_RD) || (cls == CL_FW_RD);
    end

endmodule

// File: rtl/dbg_delay_timer.sv
module dbg_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             abort,
    output logic             busy,
    output logic             first,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            first <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            first <= 1'b1;
            cnt_q <= len - 1'b1;
        end else if (abort) begin
            busy  <= 1'b0;
            first <= 1'b0;
        end else if (busy) begin
            first <= 1'b0;
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = busy && (cnt_q == '0);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && !load && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

    // R8
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && first));

endmodule

// File: rtl/dbg_frame_fsm.sv
module dbg_frame_fsm
    import dbg_frame_pkg::*;
#(
    parameter int CMD_W   = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 8,
    parameter int HW_DLY  = 150,
    parameter int FWR_DLY = 48,
    parameter int FWW_DLY = 36,
    parameter int GO_DLY  = 76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_timeout,
    output logic              rx_wide,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fw_start,
    output logic [CMD_W-1:0]  fw_cmd,
    input  logic [DATA_W-1:0] fw_rdata,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_len,
    output logic              tmr_abort,
    input  logic              tmr_busy,
    input  logic              tmr_first,
    input  logic              tmr_done
);
    seq_state_t state_q, state_d;

    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] tx_q;
    logic              cap_q;

    logic [CMD_W-1:0]  dec_in;
    cmd_class_t        cls;
    logic              need_addr, need_din, gives_data;
    logic              take;

    assign dec_in = (state_q == ST_IDLE) ? rx_data[CMD_W-1:0] : cmd_q;
    assign take   = rx_valid && !rx_timeout;

    dbg_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .cmd        (dec_in),
        .cls        (cls),
        .need_addr  (need_addr),
        .need_din   (need_din),
        .gives_data (gives_data)
    );

    always_comb begin
        unique case (cls)
            CL_HW_RD, CL_HW_WR: tmr_len = CNT_W'(HW_DLY);
            CL_FW_RD:           tmr_len = CNT_W'(FWR_DLY);
            CL_FW_WR:           tmr_len = CNT_W'(FWW_DLY);
            default:            tmr_len = CNT_W'(GO_DLY);
        endcase
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (need_addr) begin
                        state_d = ST_ADDR;
                    end else if (need_din) begin
                        state_d = ST_DIN;
                    end else begin
                        state_d  = ST_WAIT;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                if (rx_timeout) begin
                    state_d = ST_IDLE;
                end else if (rx_valid) begin
                    if (need_din) begin
                        state_d = ST_DIN;
                    end else begin
                        state_d  = ST_WAIT;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_DIN: begin
                if (rx_timeout) begin
                    state_d = ST_IDLE;
                end else if (rx_valid) begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rx_timeout) begin
                    state_d = ST_IDLE;
                end else if (tmr_done) begin
                    state_d = gives_data ? ST_DOUT : ST_IDLE;
                end
            end
            ST_DOUT: begin
                if (rx_timeout || tx_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            tx_q    <= '0;
            cap_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && take) begin
                cmd_q <= rx_data[CMD_W-1:0];
            end
            if (state_q == ST_ADDR && take) begin
                addr_q <= rx_data[ADDR_W-1:0];
            end
            if (state_q == ST_DIN && take) begin
                wdata_q <= rx_data;
            end
            cap_q <= (state_q == ST_WAIT) && tmr_first && gives_data;
            if (cap_q) begin
                tx_q <= (cls == CL_HW_RD) ? mem_rdata : fw_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        rx_wide   = 1'b0;
        tx_req    = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        fw_start  = 1'b0;
        tmr_abort = 1'b0;
        unique case (state_q)
            ST_ADDR, ST_DIN: rx_wide = 1'b1;
            ST_WAIT: begin
                tmr_abort = rx_timeout;
                if (tmr_first) begin
                    mem_rd   = (cls == CL_HW_RD);
                    mem_wr   = (cls == CL_HW_WR);
                    fw_start = !need_addr;
                end
            end
            ST_DOUT: tx_req = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign fw_cmd    = cmd_q;
    assign tx_data   = tx_q;

    // R10
    timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && state_q != ST_IDLE) |=> (state_q == ST_IDLE));

    // R3
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3
    rd_in_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || fw_start) |-> tmr_busy);

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done && !rx_timeout) |=> (tx_req && $stable(tx_data)));

    // R9
    wide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !rx_wide);

endmodule

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq
    import dbg_frame_pkg::*;
#(
    parameter int CMD_W   = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int HW_DLY  = 150,
    parameter int FWR_DLY = 48,
    parameter int FWW_DLY = 36,
    parameter int GO_DLY  = 76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_timeout,
    output logic              rx_wide,
    output logic              busy,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fw_start,
    output logic [CMD_W-1:0]  fw_cmd,
    input  logic [DATA_W-1:0] fw_rdata
);
    localparam int MAX_DLY = max_of4(HW_DLY, FWR_DLY, FWW_DLY, GO_DLY);
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    logic             tmr_load, tmr_abort, tmr_busy, tmr_first, tmr_done;
    logic [CNT_W-1:0] tmr_len;

    dbg_frame_fsm #(
        .CMD_W   (CMD_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .HW_DLY  (HW_DLY),
        .FWR_DLY (FWR_DLY),
        .FWW_DLY (FWW_DLY),
        .GO_DLY  (GO_DLY)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_timeout (rx_timeout),
        .rx_wide    (rx_wide),
        .tx_req     (tx_req),
        .tx_data    (tx_data),
        .tx_done    (tx_done),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_rdata  (mem_rdata),
        .fw_start   (fw_start),
        .fw_cmd     (fw_cmd),
        .fw_rdata   (fw_rdata),
        .tmr_load   (tmr_load),
        .tmr_len    (tmr_len),
        .tmr_abort  (tmr_abort),
        .tmr_busy   (tmr_busy),
        .tmr_first  (tmr_first),
        .tmr_done   (tmr_done)
    );

    dbg_delay_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .abort (tmr_abort),
        .busy  (tmr_busy),
        .first (tmr_first),
        .done  (tmr_done)
    );

    assign busy = tmr_busy;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !tx_req && !rx_wide));

endmodule

// File: tb/dbg_frame_seq_tb.sv
module dbg_frame_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_timeout = 1'b0;
    logic        rx_wide, busy, tx_req, tx_done;
    logic [15:0] tx_data, mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, fw_start;
    logic [7:0]  fw_cmd;
    logic [15:0] fw_rdata;

    localparam logic [15:0] FW_WORD = 16'h5A3C;

    assign fw_rdata = FW_WORD;

    always #5 clk = ~clk;

    initial tx_done = 1'b0;

    dbg_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_timeout(rx_timeout), .rx_wide(rx_wide), .busy(busy),
        .tx_req(tx_req), .tx_data(tx_data), .tx_done(tx_done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_rdata(mem_rdata), .fw_start(fw_start),
        .fw_cmd(fw_cmd), .fw_rdata(fw_rdata)
    );

    // memory stub: registered read, one cycle latency
    logic [15:0] mem [16];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) mem[k] <= '0;
            mem_rdata <= '0;
        end else begin
            if (mem_wr) mem[mem_addr[3:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];
        end
    end

    // strobe monitor
    int          n_rd = 0, n_wr = 0, n_fw = 0;
    logic [15:0] rd_addr, wr_addr, wr_data;
    logic [7:0]  fw_last;
    always @(posedge clk) begin
        if (mem_rd) begin n_rd++; rd_addr = mem_addr; end
        if (mem_wr) begin n_wr++; wr_addr = mem_addr; wr_data = mem_wdata; end
        if (fw_start) begin n_fw++; fw_last = fw_cmd; end
    end

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        rx_valid = 1'b1;
        rx_data  = w;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // counts busy cycles; injects a stray field in the fifth one
    task automatic count_busy(output int cnt);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            if (cnt == 5) begin
                rx_valid = 1'b1;
                rx_data  = 16'hFFFF;
            end else begin
                rx_valid = 1'b0;
            end
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    // {cmd, addr, data, has_addr, has_din, has_out, delay, expected out}
    localparam int NV = 9;
    localparam logic [66:0] VEC [NV] = '{
        {8'hC0, 16'h0003, 16'hA5A5, 3'b110, 8'd150, 16'h0000},
        {8'h80, 16'h0003, 16'h0000, 3'b101, 8'd150, 16'hA5A5},
        {8'hE7, 16'h000C, 16'h1234, 3'b110, 8'd150, 16'h0000},
        {8'h9F, 16'h000C, 16'h0000, 3'b101, 8'd150, 16'h1234},
        {8'h21, 16'h0000, 16'h0000, 3'b001, 8'd48,  16'h5A3C},
        {8'h44, 16'h0000, 16'hBEEF, 3'b010, 8'd36,  16'h0000},
        {8'h08, 16'h0000, 16'h0000, 3'b000, 8'd76,  16'h0000},
        {8'h00, 16'h0000, 16'h0000, 3'b000, 8'd76,  16'h0000},
        {8'h3F, 16'h0000, 16'h0000, 3'b001, 8'd48,  16'h5A3C}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        int rd0, wr0, fw0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 rx_wide", rx_wide, 0);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 strobes", {mem_rd, mem_wr, fw_start}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0]  v_cmd;
            logic [15:0] v_addr, v_data, v_exp;
            logic        ha, hd, ho;
            logic [7:0]  v_dly;
            string       tag;
            {v_cmd, v_addr, v_data, ha, hd, ho, v_dly, v_exp} = VEC[i];
            if (ha && ho)       tag = "R3";
            else if (ha)        tag = "R4";
            else if (ho)        tag = "R5";
            else if (hd)        tag = "R6";
            else                tag = "R7";
            rd0 = n_rd; wr0 = n_wr; fw0 = n_fw;
            chk("R9 command width", rx_wide, 0);
            send({8'h00, v_cmd});
            if (ha) begin
                chk("R9 address width", rx_wide, 1);
                send(v_addr);
            end
            if (hd) begin
                chk("R9 data width", rx_wide, 1);
                send(v_data);
            end
            count_busy(cnt);
            chk({"R8 delay length ", tag}, cnt, v_dly);
            if (ho) begin
                chk({tag, " tx_req"}, tx_req, 1);
                @(negedge clk);
                chk("R11 held", tx_req, 1);
                chk({tag, " result"}, tx_data, v_exp);
                tx_done = 1'b1;
                @(negedge clk);
                tx_done = 1'b0;
                chk("R11 release", tx_req, 0);
            end else begin
                chk({tag, " no result"}, tx_req, 0);
            end
            if (ha && ho) begin
                chk("R2 hw read strobe", n_rd - rd0, 1);
                chk("R3 read address", rd_addr, v_addr);
            end else if (ha) begin
                chk("R2 hw write strobe", n_wr - wr0, 1);
                chk("R4 write address", wr_addr, v_addr);
                chk("R4 write data", wr_data, v_data);
            end else begin
                chk("R2 firmware start", n_fw - fw0, 1);
                chk({tag, " fw_cmd"}, fw_last, v_cmd);
                chk("R2 no memory strobe", (n_rd - rd0) + (n_wr - wr0), 0);
            end
            @(negedge clk);
        end

        // R10: field and timeout in the same cycle while an address is expected
        rd0 = n_rd;
        send(16'h0080);
        rx_timeout = 1'b1;
        send(16'h0005);
        rx_timeout = 1'b0;
        chk("R10 dropped wide", rx_wide, 0);
        chk("R10 dropped busy", busy, 0);
        repeat (3) @(negedge clk);
        chk("R10 no read", n_rd - rd0, 0);
        send(16'h0008);
        count_busy(cnt);
        chk("R10 next frame delay", cnt, 76);

        // R10: command together with timeout in idle is not accepted
        rx_timeout = 1'b1;
        send(16'h0080);
        rx_timeout = 1'b0;
        chk("R10 idle command refused", rx_wide, 0);

        // R10: timeout in the middle of a delay
        send(16'h0008);
        repeat (4) @(negedge clk);
        rx_timeout = 1'b1;
        @(negedge clk);
        rx_timeout = 1'b0;
        chk("R10 delay aborted", busy, 0);

        // R10: timeout while the result is offered
        send(16'h0021);
        count_busy(cnt);
        chk("R5 offer", tx_req, 1);
        rx_timeout = 1'b1;
        @(negedge clk);
        rx_timeout = 1'b0;
        chk("R10 offer dropped", tx_req, 0);

        // R8: stray fields during delays left memory intact
        send(16'h0080);
        send(16'h0003);
        count_busy(cnt);
        chk("R8 memory intact", tx_data, 16'hA5A5);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule